// File: doc/BRIEF.md
# Serial ADC Readout Controller

This controller sits on the host side of a 16-bit sampling converter that is read through three wires: an active-low select, a data clock driven by the host, and a serial data line driven by the converter. A single-cycle start pulse opens a frame. The controller pulls select low and derives the data clock from the system clock. Each clock phase lasts a fixed number of system cycles, set by a parameter. The converter uses the first few clock periods to sample its input and then drives one forced-low null bit. Only after that does the result appear, most significant bit first, changing on falling clock edges. The controller therefore samples on its own rising edges and counts them exactly.

After the last needed bit the controller ends the frame. It drops the clock, raises select, and presents the word with a one-cycle valid strobe. A null bit read as high is reported as a protocol error. In verify mode, chosen per frame, the controller keeps clocking through the least-significant-bit-first repeat that the converter sends after the word. It compares that repeat with the first copy and flags any difference. Select then stays high for a guard interval before the next frame can start.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, select (cs_n) is high, the data clock (sclk) is low, and busy and valid are low.
- R2: A start pulse seen while idle drives cs_n low on the next system clock edge. While cs_n is low, every low phase and every high phase of sclk lasts exactly HALF system cycles, and the first phase is low.
- R3: A frame contains LEAD+1+WIDTH rising sclk edges (22 with the defaults) in normal mode. It contains LEAD+1+2*WIDTH rising edges (38) in verify mode. The verify input is sampled together with start.
- R4: Counting rising edges from 1, the bits sampled on edges LEAD+2 to LEAD+1+WIDTH (7 to 22) form result, with the first sampled bit as the most significant bit. Bits sampled on edges 1 to LEAD do not affect result.
- R5: null_err is set at the end of the frame if and only if the bit sampled on rising edge LEAD+1 (6) was high.
- R6: In verify mode, the bits sampled on edges 23 to 38 are taken as bit 0 up to bit 15. mismatch is set if and only if that word differs from result. In normal mode mismatch stays 0.
- R7: At the end of the frame, cs_n rises and sclk falls in the same cycle. valid is high for exactly that one cycle, and result, null_err and mismatch hold their values after it.
- R8: Between frames cs_n stays high for at least 2*HALF system cycles. A start pulse arriving while busy has no effect.
- R9: sclk is low whenever cs_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion frame |
| verify | input | 1 | Also read the bit-reversed repeat and compare it |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Data clock to the converter |
| busy | output | 1 | A frame or the guard interval is in progress |
| valid | output | 1 | One-cycle strobe when the result is ready |
| result | output | WIDTH | Converted word |
| null_err | output | 1 | Null bit was read as high |
| mismatch | output | 1 | Verify-mode repeat differed from the word |

## Verification
The checks assume that reset is released cleanly and that start is a system-synchronous pulse. They also assume verify is steady during the cycle in which start is taken. The bench drives all inputs on falling system-clock edges. Its converter model changes sdi only right after a falling sclk edge, so every rising-edge sample lands in a quiet window. The model drives ones during the sampling lead-in and after the repeat, so that bits outside the window the controller should read would visibly corrupt the result if they were taken in.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int WIDTH = 16,
  parameter int LEAD  = 5,
  parameter int HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             verify,
  input  logic             sdi,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             valid,
  output logic [WIDTH-1:0] result,
  output logic             null_err,
  output logic             mismatch
);
  localparam int NULL_EDGE = LEAD + 1;
  localparam int LAST_NORM = LEAD + 1 + WIDTH;
  localparam int LAST_VER  = LAST_NORM + WIDTH;
  localparam int EW        = $clog2(LAST_VER + 1);
  localparam int DW        = $clog2(2 * HALF + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_GUARD} st_t;

  st_t              st;
  logic [DW-1:0]    div;
  logic [EW-1:0]    edges;
  logic             ver_q;
  logic [WIDTH-1:0] word, rep;

  wire [EW-1:0] last       = ver_q ? EW'(LAST_VER) : EW'(LAST_NORM);
  wire [EW-1:0] nxt        = edges + 1'b1;
  wire          half_done  = (div == DW'(HALF - 1));
  wire          guard_done = (div == DW'(2 * HALF - 1));

  assign busy   = (st != S_IDLE);
  assign result = word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      div      <= '0;
      edges    <= '0;
      ver_q    <= 1'b0;
      word     <= '0;
      rep      <= '0;
      valid    <= 1'b0;
      null_err <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st       <= S_LOW;
          cs_n     <= 1'b0;
          div      <= '0;
          edges    <= '0;
          ver_q    <= verify;
          null_err <= 1'b0;
          mismatch <= 1'b0;
        end
        S_LOW: if (half_done) begin
          div   <= '0;
          sclk  <= 1'b1;
          st    <= S_HIGH;
          edges <= nxt;
          if (nxt == EW'(NULL_EDGE))
            null_err <= sdi;
          else if (nxt > EW'(NULL_EDGE) && nxt <= EW'(LAST_NORM))
            word <= {word[WIDTH-2:0], sdi};
          else if (nxt > EW'(LAST_NORM))
            rep <= {sdi, rep[WIDTH-1:1]};
        end else begin
          div <= div + 1'b1;
        end
        S_HIGH: if (half_done) begin
          div  <= '0;
          sclk <= 1'b0;
          if (edges == last) begin
            cs_n     <= 1'b1;
            valid    <= 1'b1;
            mismatch <= ver_q && (rep != word);
            st       <= S_GUARD;
          end else begin
            st <= S_LOW;
          end
        end else begin
          div <= div + 1'b1;
        end
        default: if (guard_done) begin
          st  <= S_IDLE;
          div <= '0;
        end else begin
          div <= div + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int WIDTH = 16,
  parameter int LEAD  = 5,
  parameter int HALF  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             verify,
  input logic             sdi,
  input logic             cs_n,
  input logic             sclk,
  input logic             busy,
  input logic             valid,
  input logic [WIDTH-1:0] result,
  input logic             null_err,
  input logic             mismatch
);
  localparam int LAST_NORM = LEAD + 1 + WIDTH;
  localparam int LAST_VER  = LAST_NORM + WIDTH;

  logic        prev_s, prev_c;
  logic [15:0] run, hi_run;
  logic [7:0]  rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s <= 1'b0;
      prev_c <= 1'b1;
      run    <= '0;
      hi_run <= 16'(4 * HALF);
      rises  <= '0;
    end else begin
      prev_s <= sclk;
      prev_c <= cs_n;
      if ((sclk != prev_s) || (!cs_n && prev_c)) run <= 16'd1;
      else if (run != 16'hFFFF) run <= run + 1'b1;
      if (!cs_n) hi_run <= '0;
      else if (hi_run < 16'(4 * HALF)) hi_run <= hi_run + 1'b1;
      if (!cs_n && prev_c) rises <= '0;
      else if (sclk && !prev_s) rises <= rises + 1'b1;
    end
  end

  a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != prev_s) |-> (run == 16'(HALF)));
  a_r3_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rises == 8'(LAST_NORM) || rises == 8'(LAST_VER)));
  a_r7_valid_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cs_n && !sclk && !prev_c));
  a_r8_guard_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && prev_c) |-> (hi_run >= 16'(2 * HALF)));
  a_r8_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  a_r9_clock_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
endmodule

bind adc_serial_reader adc_serial_reader_chk #(.WIDTH(WIDTH), .LEAD(LEAD), .HALF(HALF)) chk (.*);

// File: tb/adc_serial_reader_test.sv
`timescale 1ns/1ps
module adc_serial_reader_test;
  localparam int HALF = 2;
  localparam int PER  = 4;

  logic        clk = 0, rst_n = 0, start = 0, verify = 0;
  logic        cs_n, sclk, busy, valid, null_err, mismatch;
  logic [15:0] result;
  logic [15:0] dev_word = 0, dev_rep = 0;
  logic        dev_null = 0;
  int          fcnt = 0, rcnt = 0, errors = 0, checks = 0;
  time         last_rise = 0;
  bit          done = 0;

  always #(PER/2) clk = ~clk;

  function automatic logic dev_bit(input int f);
    int j;
    j = f - 5;
    if (j < 0)        return 1'b1;
    else if (j == 0)  return dev_null;
    else if (j <= 16) return dev_word[16 - j];
    else if (j <= 32) return dev_rep[j - 17];
    else              return 1'b1;
  endfunction

  wire sdi = dev_bit(fcnt);

  adc_serial_reader #(.WIDTH(16), .LEAD(5), .HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .verify(verify), .sdi(sdi),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .valid(valid), .result(result),
    .null_err(null_err), .mismatch(mismatch));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge cs_n) begin fcnt = 0; rcnt = 0; end
  always @(negedge sclk) fcnt = fcnt + 1;
  always @(posedge sclk) begin
    if (rcnt != 0)
      chk(($time - last_rise) == 2 * HALF * PER, "R2 sclk period", 32'($time - last_rise), 2 * HALF * PER);
    last_rise = $time;
    rcnt = rcnt + 1;
  end

  task automatic run_frame(input logic [15:0] w, input bit v, input bit nb,
                           input logic [15:0] corr, input bit poke);
    int n;
    dev_word = w; dev_null = nb; dev_rep = w ^ corr; verify = v;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(cs_n == 0 && sclk == 0, "R2 select low after start", {cs_n, sclk}, 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    n = 0;
    while (!valid && n < 2000) begin @(negedge clk); n++; end
    chk(result == w, "R4 result", result, w);
    chk(null_err == nb, "R5 null flag", null_err, nb);
    chk(mismatch == (v && corr != 0), "R6 mismatch", mismatch, (v && corr != 0));
    chk(rcnt == (v ? 38 : 22), "R3 rising edges", rcnt, v ? 38 : 22);
    chk(cs_n == 1 && sclk == 0, "R7 frame end", {cs_n, sclk}, 2);
    @(negedge clk);
    chk(valid == 0, "R7 single valid", valid, 0);
    chk(result == w && null_err == nb, "R7 outputs held", result, w);
    while (busy) begin
      chk(cs_n == 1, "R8 guard select", cs_n, 1);
      @(negedge clk);
    end
    repeat (3) begin
      @(negedge clk);
      chk(cs_n == 1 && sclk == 0, "R8 R9 no extra frame", {cs_n, sclk}, 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0 && valid == 0, "R1 reset state",
        {cs_n, sclk, busy, valid}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      run_frame(16'h0000, v[0], 0, 0, 0);
      run_frame(16'hFFFF, v[0], 0, 0, 0);
      run_frame(16'h8000, v[0], 0, 0, 0);
      run_frame(16'h0001, v[0], 0, 0, 0);
      run_frame(16'hA5A5, v[0], 0, 0, 0);
      run_frame(16'h5A5A, v[0], 0, 0, 0);
      for (int i = 0; i < 16; i++) run_frame(16'(1 << i), v[0], 0, 0, 0);
      for (int i = 1; i < 16; i++) run_frame(16'(i * 4111 + 7), v[0], 0, 0, 0);
    end
    run_frame(16'h1234, 0, 1, 0, 0);
    run_frame(16'h4321, 1, 1, 0, 0);
    for (int b = 0; b < 16; b++) run_frame(16'hC3A1, 1, 0, 16'(1 << b), 0);
    run_frame(16'h7E01, 0, 0, 16'h0100, 0);
    run_frame(16'h2468, 0, 0, 0, 1);
    run_frame(16'h9753, 1, 0, 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * PER);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule